// File: doc/BRIEF.md
# Windowed AXI-to-PCIe Address Translator

This block maps addresses from a 48-bit AXI address space onto a 64-bit remote PCIe address space through a small set of translation windows. Each window is fixed at elaboration time by three values: a lowest address, a highest address and a 64-bit translation value. An address with a valid strobe is compared against every active window in parallel. On a hit, the bits inside the window's aperture are kept as an offset. All bits above the aperture are taken from the window's translation value.

The result is registered and appears one clock after the request. It carries the translated address, the number of the window that hit, and a flag that tells the downstream packet builder whether the 64-bit address format is needed. An address that falls in no window produces a miss indication with a zeroed address. Every active window is also checked for a well-formed shape: the size must be a power of two, the base must be aligned to that size, and the translation value must have no bits set inside the aperture. Any violation raises a sticky configuration error.

Top module: `pcie_window_xlate`

## Requirements
- R1: Outputs are registered with one cycle of latency: `out_valid` equals `in_valid` from the previous rising clock edge. While `rst_n` is low, every output is 0.
- R2: A window hits when its lowest address <= `in_addr` <= its highest address. Both bounds are inclusive.
- R3: On a hit, `out_addr` keeps the address bits below the window size (log2 of size bits) and takes every bit above them from the window's 64-bit translation value. For example, window 0x1234_0000..0x1234_FFFF with translation 0x5000_0000_5671_0000 maps 0x1234_0ABC to 0x5000_0000_5671_0ABC.
- R4: On a hit, `out_hit_index` gives the window number as a 2-bit binary value (window 0 = 0, window 1 = 1, window 2 = 2).
- R5: When windows overlap, the lowest-numbered window that hits is reported and used for translation.
- R6: A valid request that hits no window gives `out_miss`=1, `out_addr`=0, `out_hit_index`=0 and `out_is_64bit`=0.
- R7: On a hit, `out_is_64bit` is 1 exactly when bits 63:32 of `out_addr` are not all zero.
- R8: In a cycle with `out_valid`=0, the outputs `out_addr`, `out_hit_index`, `out_is_64bit` and `out_miss` are all 0, whatever address was presented with it.
- R9: `config_error` rises on the first clock edge after reset if any active window is malformed. A window is malformed if its size is not a power of two, its base is not aligned to its size, or its translation value has a nonzero bit inside the aperture. Once set, `config_error` stays 1 until reset.
- R10: Only windows 0 to `NUM_WIN`-1 are active. An address inside a window numbered `NUM_WIN` or higher is a miss, and such a window never affects `config_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 48 | AXI-side address |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 64 | Translated PCIe address, 0 on a miss |
| out_hit_index | output | 2 | Number of the window that hit |
| out_is_64bit | output | 1 | Translated address needs the 64-bit format |
| out_miss | output | 1 | Valid request matched no window |
| config_error | output | 1 | Sticky flag for a malformed active window |

## Verification
Two functions can fall in the same cycle. First, a hit in two overlapping windows must be resolved by priority. Second, the width flag must be decided from the address that priority produced. The bench provokes this with a second instance whose window 0 (translated below 4 GiB) lies inside window 1 (translated above 4 GiB). Addresses that hit both windows must report window 0 with the 32-bit format. Addresses just past window 0 must report window 1 with the 64-bit format. Every cycle is compared against a behavioural model that walks the windows in order and adds the offset to the translation value.

// File: rtl/pcie_window_xlate_pkg.sv
package pcie_window_xlate_pkg;
   // largest number of windows the block can be built with
   localparam int MAX_WIN  = 3;
   // width of the remote address space
   localparam int XLATE_W  = 64;
   // width of the window number output
   localparam int IDX_W    = $clog2(MAX_WIN);
endpackage

// File: rtl/pcie_window_xlate_win.sv
// One translation window: range compare, offset merge and shape check.
module pcie_window_xlate_win
   import pcie_window_xlate_pkg::*;
#(
   parameter int                  ADDR_W = 48,
   parameter logic [ADDR_W-1:0]   BASE   = '0,
   parameter logic [ADDR_W-1:0]   HIGH   = '1,
   parameter logic [XLATE_W-1:0]  XLATE  = '0,
   parameter bit                  ENABLE = 1'b1
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit,
   output logic [XLATE_W-1:0]  xaddr,
   output logic                cfg_bad
);
   // size minus one; for a well-formed window this is the offset mask
   localparam logic [ADDR_W-1:0]  SPAN     = HIGH - BASE;
   localparam logic [XLATE_W-1:0] SPAN_X   = XLATE_W'(SPAN);
   localparam bit                 ORDER_OK = (HIGH >= BASE);
   localparam bit                 POW2_OK  = ((SPAN & (SPAN + ADDR_W'(1))) == '0);
   localparam bit                 ALIGN_OK = ((BASE & SPAN) == '0);
   localparam bit                 XL_OK    = ((XLATE & SPAN_X) == '0);

   logic in_range;

   assign in_range = (addr >= BASE) && (addr <= HIGH);
   assign hit      = ENABLE && in_range;
   assign xaddr    = (XLATE & ~SPAN_X) | (XLATE_W'(addr) & SPAN_X);

   generate
      if (ENABLE) begin : g_active
         assign cfg_bad = !(ORDER_OK && POW2_OK && ALIGN_OK && XL_OK);
      end else begin : g_idle
         assign cfg_bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pcie_window_xlate_pick.sv
// Priority select: the lowest-numbered hitting window wins.
module pcie_window_xlate_pick
   import pcie_window_xlate_pkg::*;
(
   input  logic [MAX_WIN-1:0]               hit,
   input  logic [MAX_WIN-1:0][XLATE_W-1:0]  xaddr,
   output logic                             any_hit,
   output logic [IDX_W-1:0]                 sel_idx,
   output logic [XLATE_W-1:0]               sel_addr
);
   always_comb begin
      any_hit  = 1'b0;
      sel_idx  = '0;
      sel_addr = '0;
      // walk downward so the lowest index is written last
      for (int i = MAX_WIN - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any_hit  = 1'b1;
            sel_idx  = IDX_W'(i);
            sel_addr = xaddr[i];
         end
      end
   end
endmodule

// File: rtl/pcie_window_xlate.sv
module pcie_window_xlate
   import pcie_window_xlate_pkg::*;
#(
   parameter int                                ADDR_W   = 48,
   parameter int                                NUM_WIN  = 3,
   parameter logic [MAX_WIN-1:0][ADDR_W-1:0]    WIN_BASE = {48'h0000_FE00_0000,
                                                            48'h0000_ABCD_E000,
                                                            48'h0000_1234_0000},
   parameter logic [MAX_WIN-1:0][ADDR_W-1:0]    WIN_HIGH = {48'h0000_FFFF_FFFF,
                                                            48'h0000_ABCD_FFFF,
                                                            48'h0000_1234_FFFF},
   parameter logic [MAX_WIN-1:0][XLATE_W-1:0]   WIN_XL   = {64'h7000_0000_4000_0000,
                                                            64'h6000_0000_FEDC_0000,
                                                            64'h5000_0000_5671_0000}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [ADDR_W-1:0]    in_addr,
   output logic                 out_valid,
   output logic [XLATE_W-1:0]   out_addr,
   output logic [IDX_W-1:0]     out_hit_index,
   output logic                 out_is_64bit,
   output logic                 out_miss,
   output logic                 config_error
);
   // elaboration-time parameter checks
   generate
      if (NUM_WIN < 1 || NUM_WIN > MAX_WIN) begin : g_bad_num
         $error("pcie_window_xlate: NUM_WIN out of range");
      end
      if (ADDR_W < 1 || ADDR_W > XLATE_W) begin : g_bad_width
         $error("pcie_window_xlate: ADDR_W must lie in 1..XLATE_W");
      end
   endgenerate

   logic [MAX_WIN-1:0]               win_hit;
   logic [MAX_WIN-1:0][XLATE_W-1:0]  win_xaddr;
   logic [MAX_WIN-1:0]               win_bad;
   logic                             any_hit;
   logic [IDX_W-1:0]                 sel_idx;
   logic [XLATE_W-1:0]               sel_addr;
   logic                             sel_wide;

   generate
      for (genvar g = 0; g < MAX_WIN; g++) begin : g_win
         pcie_window_xlate_win #(
            .ADDR_W (ADDR_W),
            .BASE   (WIN_BASE[g]),
            .HIGH   (WIN_HIGH[g]),
            .XLATE  (WIN_XL[g]),
            .ENABLE (g < NUM_WIN)
         ) u_win (
            .addr    (in_addr),
            .hit     (win_hit[g]),
            .xaddr   (win_xaddr[g]),
            .cfg_bad (win_bad[g])
         );
      end
   endgenerate

   pcie_window_xlate_pick u_pick (
      .hit      (win_hit),
      .xaddr    (win_xaddr),
      .any_hit  (any_hit),
      .sel_idx  (sel_idx),
      .sel_addr (sel_addr)
   );

   assign sel_wide = |sel_addr[XLATE_W-1:32];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_addr      <= '0;
         out_hit_index <= '0;
         out_is_64bit  <= 1'b0;
         out_miss      <= 1'b0;
         config_error  <= 1'b0;
      end else begin
         out_valid    <= in_valid;
         config_error <= config_error | (|win_bad);
         if (in_valid && any_hit) begin
            out_addr      <= sel_addr;
            out_hit_index <= sel_idx;
            out_is_64bit  <= sel_wide;
            out_miss      <= 1'b0;
         end else begin
            out_addr      <= '0;
            out_hit_index <= '0;
            out_is_64bit  <= 1'b0;
            out_miss      <= in_valid;
         end
      end
   end

   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_miss && out_addr == '0 && out_hit_index == '0 && !out_is_64bit));

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_miss |-> (out_valid && out_addr == '0 && !out_is_64bit));

   // R7
   wide_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_miss) |-> (out_is_64bit == (out_addr[XLATE_W-1:32] != '0)));

   // R5
   first_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && win_hit[0]) |=> (!out_miss && out_hit_index == '0));

   // R10
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_miss) |-> (int'(out_hit_index) < NUM_WIN));

   // R9
   cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      config_error |=> config_error);
endmodule

// File: tb/pcie_window_xlate_bench.sv
`timescale 1ns/1ps
module pcie_window_xlate_bench;
   typedef struct packed {
      logic        v;
      logic [63:0] a;
      logic [1:0]  idx;
      logic        w;
      logic        m;
   } exp_t;

   // configuration A: default windows
   localparam logic [2:0][47:0] A_BASE = {48'h0000_FE00_0000, 48'h0000_ABCD_E000, 48'h0000_1234_0000};
   localparam logic [2:0][47:0] A_HIGH = {48'h0000_FFFF_FFFF, 48'h0000_ABCD_FFFF, 48'h0000_1234_FFFF};
   localparam logic [2:0][63:0] A_XL   = {64'h7000_0000_4000_0000, 64'h6000_0000_FEDC_0000, 64'h5000_0000_5671_0000};
   // configuration B: window 0 inside window 1, window 2 inactive
   localparam logic [2:0][47:0] B_BASE = {48'h0000_2000_0000, 48'h0000_1000_0000, 48'h0000_1000_0000};
   localparam logic [2:0][47:0] B_HIGH = {48'h0000_2000_0FFF, 48'h0000_1FFF_FFFF, 48'h0000_1000_FFFF};
   localparam logic [2:0][63:0] B_XL   = {64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000};
   // configuration C: translation value with low bits set
   localparam logic [2:0][47:0] C_BASE = {48'h0, 48'h0, 48'h0000_0000_1000};
   localparam logic [2:0][47:0] C_HIGH = {48'h0, 48'h0, 48'h0000_0000_1FFF};
   localparam logic [2:0][63:0] C_XL   = {64'h0, 64'h0, 64'h0000_0000_5000_0100};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [47:0] in_addr = '0;
   string       cur_tag = "R1";

   logic        a_v, b_v, c_v, a_w, b_w, c_w, a_m, b_m, c_m, a_cfg, b_cfg, c_cfg;
   logic [63:0] a_a, b_a, c_a;
   logic [1:0]  a_i, b_i, c_i;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pcie_window_xlate u_pcie_window_xlate (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .out_valid(a_v), .out_addr(a_a), .out_hit_index(a_i), .out_is_64bit(a_w),
      .out_miss(a_m), .config_error(a_cfg));

   pcie_window_xlate #(.NUM_WIN(2), .WIN_BASE(B_BASE), .WIN_HIGH(B_HIGH), .WIN_XL(B_XL))
   u_pcie_window_xlate_b (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .out_valid(b_v), .out_addr(b_a), .out_hit_index(b_i), .out_is_64bit(b_w),
      .out_miss(b_m), .config_error(b_cfg));

   pcie_window_xlate #(.NUM_WIN(1), .WIN_BASE(C_BASE), .WIN_HIGH(C_HIGH), .WIN_XL(C_XL))
   u_pcie_window_xlate_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .out_valid(c_v), .out_addr(c_a), .out_hit_index(c_i), .out_is_64bit(c_w),
      .out_miss(c_m), .config_error(c_cfg));

   // behavioural reference: first window whose range holds the address
   function automatic exp_t ref_model(input int n, input logic [2:0][47:0] lo,
                                      input logic [2:0][47:0] hi, input logic [2:0][63:0] xl,
                                      input bit v, input logic [47:0] a);
      exp_t e;
      e = '0;
      e.v = v;
      if (!v) return e;
      e.m = 1'b1;
      for (int i = 0; i < n; i++) begin
         if (a >= lo[i] && a <= hi[i]) begin
            e.m   = 1'b0;
            e.idx = 2'(i);
            e.a   = xl[i] + 64'(a - lo[i]);
            e.w   = (e.a >> 32) != 64'd0;
            break;
         end
      end
      return e;
   endfunction

   exp_t  exp_a = '0, exp_b = '0;
   bit    exp_cfg = 1'b0;
   string exp_tag = "R1";

   always @(posedge clk) begin
      if (rst_n) begin
         exp_a   <= ref_model(3, A_BASE, A_HIGH, A_XL, in_valid, in_addr);
         exp_b   <= ref_model(2, B_BASE, B_HIGH, B_XL, in_valid, in_addr);
         exp_cfg <= 1'b1;
      end else begin
         exp_a   <= '0;
         exp_b   <= '0;
         exp_cfg <= 1'b0;
      end
      exp_tag <= cur_tag;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cmp(input string who, input string tag, input exp_t e,
                      input logic v, input logic [63:0] a, input logic [1:0] i,
                      input logic w, input logic m);
      chk(v === e.v,   tag, {who, " out_valid"},     64'(v), 64'(e.v));
      chk(a === e.a,   tag, {who, " out_addr"},      a, e.a);
      chk(i === e.idx, tag, {who, " out_hit_index"}, 64'(i), 64'(e.idx));
      chk(w === e.w,   tag, {who, " out_is_64bit"},  64'(w), 64'(e.w));
      chk(m === e.m,   tag, {who, " out_miss"},      64'(m), 64'(e.m));
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            cmp("A", "R1", '0, a_v, a_a, a_i, a_w, a_m);
            cmp("B", "R1", '0, b_v, b_a, b_i, b_w, b_m);
            chk(c_cfg === 1'b0, "R9", "C config_error in reset", 64'(c_cfg), 64'd0);
         end else begin
            cmp("A", exp_tag, exp_a, a_v, a_a, a_i, a_w, a_m);
            cmp("B", exp_tag, exp_b, b_v, b_a, b_i, b_w, b_m);
            chk(c_cfg === exp_cfg, "R9", "C config_error", 64'(c_cfg), 64'(exp_cfg));
         end
         chk(a_cfg === 1'b0, "R9", "A config_error", 64'(a_cfg), 64'd0);
         chk(b_cfg === 1'b0, "R10", "B config_error", 64'(b_cfg), 64'd0);
      end
   end

   task automatic send(input bit v, input logic [47:0] a, input string tag);
      @(posedge clk);
      #1;
      in_valid = v;
      in_addr  = a;
      cur_tag  = tag;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      send(1'b0, 48'h0, "R8");
      // R3 translation vectors
      send(1'b1, 48'h0000_1234_0ABC, "R3");
      send(1'b1, 48'h0000_ABCD_F123, "R3");
      send(1'b1, 48'h0000_FFFE_DCBA, "R3");
      // R2 inclusive bounds
      send(1'b1, 48'h0000_1234_0000, "R2");
      send(1'b1, 48'h0000_1234_FFFF, "R2");
      send(1'b1, 48'h0000_ABCD_E000, "R2");
      send(1'b1, 48'h0000_FE00_0000, "R2");
      send(1'b1, 48'h0000_FFFF_FFFF, "R2");
      // R6 misses just outside windows
      send(1'b1, 48'h0000_1233_FFFF, "R6");
      send(1'b1, 48'h0000_1235_0000, "R6");
      send(1'b1, 48'h0001_0000_0000, "R6");
      send(1'b1, 48'h0000_ABCD_DFFF, "R6");
      // R8 idle with an in-window address
      send(1'b0, 48'h0000_1234_0ABC, "R8");
      // R1 alternating strobe
      for (int k = 0; k < 6; k++)
         send(k[0], 48'h0000_ABCD_E000 + 48'(k * 'h111), "R1");
      // R5 and R7 overlap in configuration B
      send(1'b1, 48'h0000_1000_1234, "R5");
      send(1'b1, 48'h0000_1000_FFFF, "R5");
      send(1'b1, 48'h0000_1001_0000, "R7");
      send(1'b1, 48'h0000_1FFF_FFFF, "R7");
      send(1'b1, 48'h0000_1000_0000, "R4");
      // R10 address in inactive window of configuration B
      send(1'b1, 48'h0000_2000_0010, "R10");
      send(1'b1, 48'h0000_2000_0FFF, "R10");
      // R9 mid-run reset clears, then sets again
      @(posedge clk);
      #1 rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      // R3 R4 mixed stimulus
      for (int k = 0; k < 200; k++) begin
         logic [47:0] a;
         int sel;
         sel = int'($urandom % 6);
         case (sel)
            0: a = 48'h0000_1234_0000 + 48'($urandom % 32'h1_0000);
            1: a = 48'h0000_ABCD_E000 + 48'($urandom % 32'h2000);
            2: a = 48'h0000_FE00_0000 + 48'($urandom % 32'h200_0000);
            3: a = 48'h0000_1000_0000 + 48'($urandom % 32'h2_0000);
            4: a = 48'h0000_1000_0000 + 48'($urandom % 32'h1000_0000);
            default: a = {16'($urandom), 32'($urandom)};
         endcase
         send(($urandom % 4) != 0, a, "R4");
      end
      send(1'b0, 48'h0, "R8");
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule